// File: doc/BRIEF.md
# Indexed Configuration Register Port

This block is a small register window on an 8-bit synchronous I/O bus. It answers at two port addresses. At the index port (22h), software writes the number of a register. At the data port (23h), it then reads or writes that register. Behind the window are two read-only identification bytes and a parameterised bank of 8-bit read/write configuration registers. On every bus cycle the block decides whether it serves the access on-chip. If it does not, it tells the surrounding logic to send the cycle to the external bus.

An index selection is good for exactly one data-port access. The selection can then be used once. The first data access after an index write is served by the block and consumes the selection. Any further data access before a new index write is not claimed. It is flagged as an external I/O cycle. Accesses to any other I/O address pass through untouched. Those accesses do not affect the selection.

Top module: `cfgport_top`

## Requirements
- R1: After reset, the index register is 00h, the selection is not valid and every configuration register holds the `CFG_RESET` value. With no access in progress, `ioClaim`, `extCycle` and `ioRdata` are all low.
- R2: A write to the index port loads the index and marks the selection valid. The access is claimed and never forwarded. A read of the index port is claimed, returns the last index written and leaves the selection unchanged.
- R3: A data-port access made while the selection is valid is claimed in the same cycle with `extCycle` low. A read returns the selected register on `ioRdata` in that cycle.
- R4: Any data-port access, read or write, ends the selection. A data-port access made with no valid selection raises `extCycle`, keeps `ioClaim` low, returns 00h on `ioRdata` and changes no register.
- R5: Index FEh reads the `DIR0` identification byte. Index FFh reads `DIR1`, whose bits 7:4 are the step number and bits 3:0 are the revision number.
- R6: Writes through the data port to index FEh or FFh leave both identification bytes unchanged.
- R7: Indices `CFG_BASE` up to `CFG_BASE+NUM_CFG-1` each select one 8-bit configuration register. A claimed data write stores `ioWdata`, and a later read returns it.
- R8: Any other index below FEh reads as FFh and ignores writes. An access to such an index still consumes the selection.
- R9: An access to any I/O address other than the two ports is never claimed, never forwarded, returns 00h and leaves the selection unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low synchronous reset |
| ioAddr | input | ADDR_W | I/O address of the current cycle |
| ioRd | input | 1 | Read strobe, one cycle per access |
| ioWr | input | 1 | Write strobe, one cycle per access; takes precedence over ioRd |
| ioWdata | input | 8 | Write data |
| ioRdata | output | 8 | Read data, 00h unless a claimed read is in progress |
| ioClaim | output | 1 | The block serves the current access |
| extCycle | output | 1 | A data-port access must be forwarded off-chip |

## Verification
The hardest situation to reach is a data-port access that finds the selection already consumed. The hardest variant is a forwarded write whose data must not land in a register. The stimulus reaches it by reading a configuration register once, then writing and reading the data port again without a new index. It then reselects the same index to show the old value survived. The stimulus also puts accesses to unrelated addresses between an index write and its data access. These include an address that aliases the index port in its low byte. This shows that those accesses neither consume nor renew the selection.

// File: rtl/cfgport_pkg.sv
package cfgport_pkg;

  // Strobes from the bus decoder to the register datapath, one cycle wide.
  typedef struct packed {
    logic idxWrite;   // load index register
    logic idxRead;    // drive index register on read data
    logic dataWrite;  // claimed write to the selected register
    logic dataRead;   // claimed read of the selected register
  } cfgStrobe_t;

endpackage

// File: rtl/cfgport_ctrl.sv
module cfgport_ctrl
  import cfgport_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int INDEX_PORT = 'h22,
  parameter int DATA_PORT  = 'h23
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] ioAddr,
  input  logic              ioRd,
  input  logic              ioWr,
  output cfgStrobe_t        strobe,
  output logic              claim,
  output logic              extFwd
);

  localparam logic [ADDR_W-1:0] IdxAddr  = ADDR_W'(INDEX_PORT);
  localparam logic [ADDR_W-1:0] DataAddr = ADDR_W'(DATA_PORT);

  logic atIdx, atData, anyAccess, rdOnly, selValid;

  assign atIdx     = (ioAddr == IdxAddr);
  assign atData    = (ioAddr == DataAddr);
  assign anyAccess = ioRd | ioWr;
  assign rdOnly    = ioRd & ~ioWr;

  always_comb begin
    strobe.idxWrite  = atIdx & ioWr;
    strobe.idxRead   = atIdx & rdOnly;
    strobe.dataWrite = atData & ioWr & selValid;
    strobe.dataRead  = atData & rdOnly & selValid;
  end

  assign claim  = (atIdx & anyAccess) | (atData & anyAccess & selValid);
  assign extFwd = atData & anyAccess & ~selValid;

  // Selection is single-use: set by an index write, spent by any data access.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      selValid <= 1'b0;
    end else if (atIdx & ioWr) begin
      selValid <= 1'b1;
    end else if (atData & anyAccess) begin
      selValid <= 1'b0;
    end
  end

endmodule

// File: rtl/cfgport_regs.sv
module cfgport_regs
  import cfgport_pkg::*;
#(
  parameter logic [7:0] DIR0      = 8'h42,
  parameter logic [7:0] DIR1      = 8'h25,
  parameter int         NUM_CFG   = 8,
  parameter int         CFG_BASE  = 'hC0,
  parameter logic [7:0] CFG_RESET = 8'h00
) (
  input  logic       clk,
  input  logic       rstN,
  input  cfgStrobe_t strobe,
  input  logic [7:0] wdata,
  output logic [7:0] rdata
);

  localparam logic [7:0] IdHiIdx = 8'hFF;
  localparam logic [7:0] IdLoIdx = 8'hFE;

  logic [7:0]   indexQ;
  logic [7:0]   cfgQ [NUM_CFG];
  logic [NUM_CFG-1:0] cfgHit;
  logic [7:0]   cfgRd;
  logic [7:0]   selData;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      indexQ <= 8'h00;
    end else if (strobe.idxWrite) begin
      indexQ <= wdata;
    end
  end

  for (genvar gi = 0; gi < NUM_CFG; gi++) begin : g_cfg
    localparam logic [7:0] Slot = 8'(CFG_BASE + gi);
    assign cfgHit[gi] = (indexQ == Slot);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        cfgQ[gi] <= CFG_RESET;
      end else if (strobe.dataWrite && cfgHit[gi]) begin
        cfgQ[gi] <= wdata;
      end
    end
  end

  always_comb begin
    cfgRd = 8'hFF;
    for (int i = 0; i < NUM_CFG; i++) begin
      if (cfgHit[i]) cfgRd = cfgQ[i];
    end
  end

  always_comb begin
    if (indexQ == IdLoIdx)      selData = DIR0;
    else if (indexQ == IdHiIdx) selData = DIR1;
    else                        selData = cfgRd;
  end

  always_comb begin
    if (strobe.idxRead)       rdata = indexQ;
    else if (strobe.dataRead) rdata = selData;
    else                      rdata = 8'h00;
  end

endmodule

// File: rtl/cfgport_top.sv
module cfgport_top
  import cfgport_pkg::*;
#(
  parameter int         ADDR_W    = 16,
  parameter logic [7:0] DIR0      = 8'h42,
  parameter logic [7:0] DIR1      = 8'h25,
  parameter int         NUM_CFG   = 8,
  parameter int         CFG_BASE  = 'hC0,
  parameter logic [7:0] CFG_RESET = 8'h00
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] ioAddr,
  input  logic              ioRd,
  input  logic              ioWr,
  input  logic [7:0]        ioWdata,
  output logic [7:0]        ioRdata,
  output logic              ioClaim,
  output logic              extCycle
);

  cfgStrobe_t strobe;

  cfgport_ctrl #(
    .ADDR_W    (ADDR_W),
    .INDEX_PORT('h22),
    .DATA_PORT ('h23)
  ) u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .ioAddr(ioAddr),
    .ioRd  (ioRd),
    .ioWr  (ioWr),
    .strobe(strobe),
    .claim (ioClaim),
    .extFwd(extCycle)
  );

  cfgport_regs #(
    .DIR0     (DIR0),
    .DIR1     (DIR1),
    .NUM_CFG  (NUM_CFG),
    .CFG_BASE (CFG_BASE),
    .CFG_RESET(CFG_RESET)
  ) u_regs (
    .clk   (clk),
    .rstN  (rstN),
    .strobe(strobe),
    .wdata (ioWdata),
    .rdata (ioRdata)
  );

endmodule

// File: rtl/cfgport_chk.sv
module cfgport_chk #(
  parameter int         ADDR_W = 16,
  parameter logic [7:0] DIR0   = 8'h42,
  parameter logic [7:0] DIR1   = 8'h25
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] ioAddr,
  input logic              ioRd,
  input logic              ioWr,
  input logic [7:0]        ioWdata,
  input logic [7:0]        ioRdata,
  input logic              ioClaim,
  input logic              extCycle
);

  logic atIdx, atData, acc, rdOnly;
  logic shValid;
  logic [7:0] shIdx;

  assign atIdx  = (ioAddr == ADDR_W'('h22));
  assign atData = (ioAddr == ADDR_W'('h23));
  assign acc    = ioRd | ioWr;
  assign rdOnly = ioRd & ~ioWr;

  // Port-level model of the single-use selection.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      shValid <= 1'b0;
      shIdx   <= 8'h00;
    end else if (atIdx & ioWr) begin
      shValid <= 1'b1;
      shIdx   <= ioWdata;
    end else if (atData & acc) begin
      shValid <= 1'b0;
    end
  end

  // R3
  data_served_chk: assert property (@(posedge clk) disable iff (!rstN)
    (atData && acc && shValid) |-> (ioClaim && !extCycle));

  // R4
  data_forwarded_chk: assert property (@(posedge clk) disable iff (!rstN)
    (atData && acc && !shValid) |-> (extCycle && !ioClaim && ioRdata == 8'h00));

  // R9
  foreign_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (acc && !atIdx && !atData) |-> (!ioClaim && !extCycle && ioRdata == 8'h00));

  // R2
  index_readback_chk: assert property (@(posedge clk) disable iff (!rstN)
    (atIdx && rdOnly) |-> (ioClaim && !extCycle && ioRdata == shIdx));

  // R5
  id_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    (atData && rdOnly && shValid && shIdx == 8'hFE) |-> (ioRdata == DIR0));

  // R5
  id_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    (atData && rdOnly && shValid && shIdx == 8'hFF) |-> (ioRdata == DIR1));

  // R4
  never_both_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(ioClaim && extCycle));

endmodule

bind cfgport_top cfgport_chk #(
  .ADDR_W(ADDR_W),
  .DIR0  (DIR0),
  .DIR1  (DIR1)
) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .ioAddr  (ioAddr),
  .ioRd    (ioRd),
  .ioWr    (ioWr),
  .ioWdata (ioWdata),
  .ioRdata (ioRdata),
  .ioClaim (ioClaim),
  .extCycle(extCycle)
);

// File: tb/tb_cfgport_top.sv
module tb_cfgport_top;

  localparam int         ADDR_W    = 16;
  localparam logic [7:0] DIR0      = 8'h42;
  localparam logic [7:0] DIR1      = 8'h25;
  localparam int         NUM_CFG   = 8;
  localparam int         CFG_BASE  = 'hC0;
  localparam logic [7:0] CFG_RESET = 8'h00;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [ADDR_W-1:0] ioAddr = '0;
  logic              ioRd = 1'b0;
  logic              ioWr = 1'b0;
  logic [7:0]        ioWdata = 8'h00;
  logic [7:0]        ioRdata;
  logic              ioClaim;
  logic              extCycle;

  always #10 clk = ~clk;  // 50 MHz

  cfgport_top #(
    .ADDR_W(ADDR_W), .DIR0(DIR0), .DIR1(DIR1),
    .NUM_CFG(NUM_CFG), .CFG_BASE(CFG_BASE), .CFG_RESET(CFG_RESET)
  ) dut (
    .clk(clk), .rstN(rstN), .ioAddr(ioAddr), .ioRd(ioRd), .ioWr(ioWr),
    .ioWdata(ioWdata), .ioRdata(ioRdata), .ioClaim(ioClaim), .extCycle(extCycle)
  );

  typedef struct {
    logic [7:0] rdata;
    logic       claim;
    logic       ext;
    string      tag;
  } expItem_t;

  expItem_t expQ[$];
  int nTests = 0;
  int nFail  = 0;
  bit done   = 0;

  // Reference model built from the requirements.
  logic [7:0] mIdx;
  bit         mValid;
  logic [7:0] mCfg [NUM_CFG];

  function automatic logic [7:0] modelRead(logic [7:0] idx);
    if (idx == 8'hFE) return DIR0;
    if (idx == 8'hFF) return DIR1;
    if (int'(idx) >= CFG_BASE && int'(idx) < CFG_BASE + NUM_CFG)
      return mCfg[int'(idx) - CFG_BASE];
    return 8'hFF;
  endfunction

  task automatic access(input logic [ADDR_W-1:0] a, input bit wr,
                        input logic [7:0] wd, input string tag);
    expItem_t e;
    bool_t_dummy: begin end
    @(negedge clk);
    ioAddr = a; ioWr = wr; ioRd = ~wr; ioWdata = wd;
    e.tag = tag; e.rdata = 8'h00; e.claim = 1'b0; e.ext = 1'b0;
    if (a == ADDR_W'('h22)) begin
      e.claim = 1'b1;
      if (wr) begin mIdx = wd; mValid = 1; end
      else e.rdata = mIdx;
    end else if (a == ADDR_W'('h23)) begin
      if (mValid) begin
        e.claim = 1'b1;
        if (wr) begin
          if (int'(mIdx) >= CFG_BASE && int'(mIdx) < CFG_BASE + NUM_CFG)
            mCfg[int'(mIdx) - CFG_BASE] = wd;
        end else e.rdata = modelRead(mIdx);
      end else e.ext = 1'b1;
      mValid = 0;
    end
    expQ.push_back(e);
    @(posedge clk);
    @(negedge clk);
    ioRd = 0; ioWr = 0; ioAddr = '0; ioWdata = 8'h00;
  endtask

  task automatic sel(input logic [7:0] idx, input string tag);
    access(ADDR_W'('h22), 1, idx, tag);
  endtask

  // Monitor: compare every access against the queued expectation.
  initial begin
    forever begin
      @(negedge clk);
      #5;
      if (expQ.size() > 0) begin
        expItem_t e;
        e = expQ.pop_front();
        nTests++;
        if (ioRdata !== e.rdata || ioClaim !== e.claim || extCycle !== e.ext) begin
          nFail++;
          $display("FAIL %s: got rdata=%02h claim=%0b ext=%0b, expected rdata=%02h claim=%0b ext=%0b",
                   e.tag, ioRdata, ioClaim, extCycle, e.rdata, e.claim, e.ext);
        end
      end
    end
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      nTests++; nFail++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    mIdx = 8'h00; mValid = 0;
    for (int i = 0; i < NUM_CFG; i++) mCfg[i] = CFG_RESET;
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    @(negedge clk); #5;
    nTests++;
    if (ioRdata !== 8'h00 || ioClaim !== 1'b0 || extCycle !== 1'b0) begin
      nFail++;
      $display("FAIL R1 idle: got rdata=%02h claim=%0b ext=%0b, expected 00/0/0",
               ioRdata, ioClaim, extCycle);
    end

    access(ADDR_W'('h22), 0, 8'h00, "R1 index reads 00 after reset");
    access(ADDR_W'('h23), 0, 8'h00, "R1 no selection after reset");
    sel(8'hC0, "R2 index write");
    access(ADDR_W'('h22), 0, 8'h00, "R2 index readback");
    access(ADDR_W'('h23), 0, 8'h00, "R1 cfg reset value");

    sel(8'hC0, "R7 select");
    access(ADDR_W'('h23), 1, 8'h5A, "R7 write");
    sel(8'hC0, "R7 reselect");
    access(ADDR_W'('h23), 0, 8'h00, "R3 read served");
    access(ADDR_W'('h23), 0, 8'h00, "R4 second read forwarded");
    access(ADDR_W'('h23), 1, 8'h77, "R4 stale write forwarded");
    sel(8'hC0, "R4 reselect");
    access(ADDR_W'('h23), 0, 8'h00, "R4 stale write ignored");

    sel(8'hFE, "R5 select id low");
    access(ADDR_W'('h23), 0, 8'h00, "R5 id low");
    sel(8'hFF, "R5 select id high");
    access(ADDR_W'('h23), 0, 8'h00, "R5 id high");
    sel(8'hFE, "R6 select");
    access(ADDR_W'('h23), 1, 8'h00, "R6 write id low");
    sel(8'hFF, "R6 select");
    access(ADDR_W'('h23), 1, 8'hAA, "R6 write id high");
    sel(8'hFE, "R6 reselect");
    access(ADDR_W'('h23), 0, 8'h00, "R6 id low unchanged");
    sel(8'hFF, "R6 reselect");
    access(ADDR_W'('h23), 0, 8'h00, "R6 id high unchanged");

    sel(8'h10, "R8 select hole");
    access(ADDR_W'('h23), 0, 8'h00, "R8 hole reads FF");
    access(ADDR_W'('h23), 0, 8'h00, "R8 hole consumed");
    sel(8'h10, "R8 select hole");
    access(ADDR_W'('h23), 1, 8'h33, "R8 hole write");
    access(ADDR_W'('h23), 1, 8'h44, "R8 hole write consumed");
    sel(8'(CFG_BASE + NUM_CFG), "R8 select past bank");
    access(ADDR_W'('h23), 0, 8'h00, "R8 past bank reads FF");

    sel(8'hC0, "R9 select");
    access(ADDR_W'('h24), 1, 8'h99, "R9 foreign write");
    access(ADDR_W'('h122), 0, 8'h00, "R9 alias read");
    access(ADDR_W'('h123), 1, 8'h11, "R9 alias write");
    access(ADDR_W'('h23), 0, 8'h00, "R9 selection kept");

    for (int i = 0; i < NUM_CFG; i++) begin
      sel(8'(CFG_BASE + i), "R7 bank select");
      access(ADDR_W'('h23), 1, 8'(i * 17 + 3), "R7 bank write");
    end
    for (int i = 0; i < NUM_CFG; i++) begin
      sel(8'(CFG_BASE + i), "R7 bank select");
      access(ADDR_W'('h23), 0, 8'h00, "R7 bank readback");
    end

    repeat (3) @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule